// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device side of a small serial nonvolatile memory, built as synthesizable logic so that a host controller can be exercised against it inside one chip or one simulation. It holds 64 words of 16 bits in registers. The host selects it with a chip-select line, shifts commands in on a serial data line with a shift clock, and reads back data or a ready/busy flag on a serial output that has its own output enable. All pins are sampled by a system clock through a configurable synchronizer, and shift-clock rising edges are detected from the sampled pin.

Each command is a start bit, a two-bit opcode and a six-bit address, sent most significant bit first. Reads return a zero placeholder bit followed by the word. Writes and erases change the array only while a programming-enable latch is set. Each accepted write or erase launches a self-timed busy period whose length is a parameter in system clock cycles. During that period the output pin, after chip select is dropped and raised again, reports 0 while busy and 1 once finished.

Top module: `twe_serial_eeprom`

## Requirements
- R1: After reset the output enable is low, every word reads as 0x0000 and programming is disabled, so a write issued before any enable leaves the word unchanged.
- R2: While chip select is high and the block is idle, zeros on the data input at shift-clock rising edges are skipped; the first 1 is the start bit, followed by opcode bit 1, opcode bit 0 and address bits 5 down to 0.
- R3: Opcode 10 reads: at the rising edge that takes address bit 0 the output is enabled and shows a 0 placeholder, each of the next 16 rising edges presents data bits 15 down to 0, and the 17th such edge disables the output. Reads work whether programming is enabled or not.
- R4: Opcode 01 takes 16 data bits, most significant first, after the address and stores them in the addressed word when programming is enabled.
- R5: Opcode 11 sets the addressed word to 0xFFFF when programming is enabled.
- R6: Opcode 00 with address bits 5:4 equal to 11 enables programming and with 00 disables it; address bits 3:0 are ignored, and the enabled state persists across any number of commands until a disable or a reset.
- R7: Opcode 00 with address bits 5:4 equal to 10 sets every word to 0xFFFF; with 01 it takes 16 data bits and writes them to every word; both only when programming is enabled.
- R8: An accepted write, erase, erase-all or write-all starts a busy period of PROG_CYCLES clock cycles; if chip select is lowered and raised during it, the output is enabled and shows 0 while busy, then 1 once the period has ended, until chip select falls.
- R9: If chip select is raised only after the busy period has ended, no status is shown and the output enable stays low.
- R10: Commands sent while the busy period runs are ignored and change no word.
- R11: The output enable is low whenever chip select is low and whenever neither read data nor status is being presented, including after a write or control command completes.
- R12: While programming is disabled, write, erase, erase-all and write-all leave every word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial shift clock; rising edges advance the command |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output: read bits or ready/busy flag |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
On every cycle the checker confirms that a deselected chip has its output released on the next cycle, that no array update happens without the enable latch or during a busy period, that an accepted command raises busy on the following cycle, and that status mode shows a driven 0 while busy. Command framing with leading zeros, the placeholder bit and bit order of reads, the effect of each opcode on stored data, persistence of the enable latch, the 0-to-1 status change at the end of the busy period, and the absence of status when chip select rises late can only be shown by the bench's command sequences, which compare read-back words against a model of the array.

// File: rtl/twe_pkg.sv
package twe_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_READ,
      ST_STAT,
      ST_HOLD
   } twe_state_e;

   // Opcode field, two bits after the start bit
   localparam logic [1:0] OP_SPECIAL = 2'b00;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_ERASE   = 2'b11;

   // Sub-command in the top two address bits when the opcode is special
   localparam logic [1:0] SP_LOCK    = 2'b00;
   localparam logic [1:0] SP_FILLWR  = 2'b01;
   localparam logic [1:0] SP_FILLER  = 2'b10;
   localparam logic [1:0] SP_UNLOCK  = 2'b11;
endpackage

// File: rtl/twe_pin_sync.sv
module twe_pin_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 0) begin : g_bad_stages
      $error("twe_pin_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
               chain_q[s] <= chain_q[s-1];
            end
         end
      end
      assign q_o = chain_q[STAGES-1];
   end
endmodule

// File: rtl/twe_prog_timer.sv
module twe_prog_timer #(
   parameter int CYCLES = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("twe_prog_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (start_i) begin
         left_q <= CW'(CYCLES);
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy_o = (left_q != '0);
endmodule

// File: rtl/twe_word_array.sv
module twe_word_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_one_i,
   input  logic              we_all_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] cell_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) begin
            cell_q[w] <= '0;
         end
      end else begin
         for (int w = 0; w < WORDS; w++) begin
            if (we_all_i || (we_one_i && (waddr_i == ADDR_W'(w)))) begin
               cell_q[w] <= wdata_i;
            end
         end
      end
   end

   assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/twe_cmd_fsm.sv
module twe_cmd_fsm
   import twe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              cs_rise_i,
   input  logic              sck_rise_i,
   input  logic              sdi_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] raddr_o,
   output logic              we_one_o,
   output logic              we_all_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              start_o,
   output logic              prog_en_o,
   output logic              stat_o,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   localparam int HDR_W = 2 + ADDR_W;
   localparam int MAXB  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
   localparam int CNT_W = $clog2(MAXB + 1);

   twe_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [HDR_W-1:0]  hdr_q;
   logic [DATA_W-1:0] dat_q;
   logic [DATA_W-1:0] rd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              all_q;
   logic              en_q;
   logic              dout_q;
   logic              roe_q;
   logic              we_one_q;
   logic              we_all_q;
   logic              start_q;
   logic [ADDR_W-1:0] waddr_q;
   logic [DATA_W-1:0] wdata_q;

   logic [HDR_W-1:0]  hdr_full;
   logic [DATA_W-1:0] dat_full;
   logic [1:0]        hdr_op;
   logic [ADDR_W-1:0] hdr_addr;
   logic [1:0]        hdr_sub;

   assign hdr_full = {hdr_q[HDR_W-2:0], sdi_i};
   assign dat_full = {dat_q[DATA_W-2:0], sdi_i};
   assign hdr_op   = hdr_full[HDR_W-1 -: 2];
   assign hdr_addr = hdr_full[ADDR_W-1:0];
   assign hdr_sub  = hdr_addr[ADDR_W-1 -: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         hdr_q    <= '0;
         dat_q    <= '0;
         rd_q     <= '0;
         addr_q   <= '0;
         all_q    <= 1'b0;
         en_q     <= 1'b0;
         dout_q   <= 1'b0;
         roe_q    <= 1'b0;
         we_one_q <= 1'b0;
         we_all_q <= 1'b0;
         start_q  <= 1'b0;
         waddr_q  <= '0;
         wdata_q  <= '0;
      end else begin
         we_one_q <= 1'b0;
         we_all_q <= 1'b0;
         start_q  <= 1'b0;
         if (!cs_i) begin
            state_q <= ST_IDLE;
            roe_q   <= 1'b0;
         end else if (cs_rise_i) begin
            state_q <= busy_i ? ST_STAT : ST_IDLE;
            roe_q   <= 1'b0;
         end else if (sck_rise_i) begin
            unique case (state_q)
               ST_IDLE: begin
                  if (sdi_i && !busy_i) begin
                     state_q <= ST_HDR;
                     cnt_q   <= '0;
                     hdr_q   <= '0;
                  end
               end
               ST_HDR: begin
                  hdr_q <= hdr_full;
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(HDR_W - 1)) begin
                     cnt_q  <= '0;
                     addr_q <= hdr_addr;
                     state_q <= ST_HOLD;
                     unique case (hdr_op)
                        OP_READ: begin
                           rd_q    <= rdata_i;
                           dout_q  <= 1'b0;
                           roe_q   <= 1'b1;
                           state_q <= ST_READ;
                        end
                        OP_WRITE: begin
                           all_q   <= 1'b0;
                           state_q <= ST_DATA;
                        end
                        OP_ERASE: begin
                           if (en_q) begin
                              waddr_q  <= hdr_addr;
                              wdata_q  <= '1;
                              we_one_q <= 1'b1;
                              start_q  <= 1'b1;
                           end
                        end
                        default: begin
                           unique case (hdr_sub)
                              SP_UNLOCK: en_q <= 1'b1;
                              SP_LOCK:   en_q <= 1'b0;
                              SP_FILLER: begin
                                 if (en_q) begin
                                    wdata_q  <= '1;
                                    we_all_q <= 1'b1;
                                    start_q  <= 1'b1;
                                 end
                              end
                              default: begin
                                 all_q   <= 1'b1;
                                 state_q <= ST_DATA;
                              end
                           endcase
                        end
                     endcase
                  end
               end
               ST_DATA: begin
                  dat_q <= dat_full;
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(DATA_W - 1)) begin
                     state_q <= ST_HOLD;
                     if (en_q) begin
                        waddr_q  <= addr_q;
                        wdata_q  <= dat_full;
                        we_one_q <= !all_q;
                        we_all_q <= all_q;
                        start_q  <= 1'b1;
                     end
                  end
               end
               ST_READ: begin
                  if (cnt_q == CNT_W'(DATA_W)) begin
                     roe_q   <= 1'b0;
                     state_q <= ST_HOLD;
                  end else begin
                     dout_q <= rd_q[DATA_W-1];
                     rd_q   <= {rd_q[DATA_W-2:0], 1'b0};
                     cnt_q  <= cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign raddr_o   = hdr_addr;
   assign we_one_o  = we_one_q;
   assign we_all_o  = we_all_q;
   assign waddr_o   = waddr_q;
   assign wdata_o   = wdata_q;
   assign start_o   = start_q;
   assign prog_en_o = en_q;
   assign stat_o    = (state_q == ST_STAT);
   assign sdo_o     = stat_o ? !busy_i : dout_q;
   assign sdo_oe_o  = stat_o | roe_q;
endmodule

// File: rtl/twe_serial_eeprom.sv
module twe_serial_eeprom #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 300,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic sdi_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("twe_serial_eeprom: ADDR_W must be at least 2 for special commands");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("twe_serial_eeprom: DATA_W must be at least 2");
   end

   logic [2:0]        pins_s;
   logic              cs_s, sck_s, sdi_s;
   logic              cs_q, sck_q;
   logic              cs_rise, sck_rise;
   logic              busy, start, prog_en, stat;
   logic              we_one, we_all;
   logic [ADDR_W-1:0] raddr, waddr;
   logic [DATA_W-1:0] rdata, wdata;

   twe_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_i, sck_i, sdi_i}),
      .q_o   (pins_s)
   );
   assign {cs_s, sck_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b0;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
      end
   end
   assign cs_rise  = cs_s & ~cs_q;
   assign sck_rise = sck_s & ~sck_q;

   twe_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_i       (cs_s),
      .cs_rise_i  (cs_rise),
      .sck_rise_i (sck_rise),
      .sdi_i      (sdi_s),
      .busy_i     (busy),
      .rdata_i    (rdata),
      .raddr_o    (raddr),
      .we_one_o   (we_one),
      .we_all_o   (we_all),
      .waddr_o    (waddr),
      .wdata_o    (wdata),
      .start_o    (start),
      .prog_en_o  (prog_en),
      .stat_o     (stat),
      .sdo_o      (sdo_o),
      .sdo_oe_o   (sdo_oe_o)
   );

   twe_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_one_i (we_one),
      .we_all_i (we_all),
      .waddr_i  (waddr),
      .wdata_i  (wdata),
      .raddr_i  (raddr),
      .rdata_o  (rdata)
   );

   twe_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .busy_o  (busy)
   );
endmodule

// File: rtl/twe_serial_eeprom_chk.sv
module twe_serial_eeprom_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic sdo_o,
   input logic sdo_oe_o,
   input logic busy,
   input logic start,
   input logic we_any,
   input logic prog_en,
   input logic stat
);
   // R11
   oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !sdo_oe_o);

   // R12
   update_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_any |-> prog_en);

   // R10
   update_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_any |-> !busy);

   // R8
   busy_shows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && busy) |-> (sdo_oe_o && !sdo_o));

   // R8
   start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

bind twe_serial_eeprom twe_serial_eeprom_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_s     (cs_s),
   .sdo_o    (sdo_o),
   .sdo_oe_o (sdo_oe_o),
   .busy     (busy),
   .start    (start),
   .we_any   (we_one | we_all),
   .prog_en  (prog_en),
   .stat     (stat)
);

// File: tb/test_twe_serial_eeprom.sv
module test_twe_serial_eeprom;
   localparam int PROG = 300;
   localparam int H    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sck = 1'b0, sdi = 1'b0;
   logic sdo, sdo_oe;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   logic [15:0] mem_m [64];
   logic        en_m;

   always #10 clk = ~clk;

   twe_serial_eeprom #(.PROG_CYCLES(PROG)) i_twe_serial_eeprom (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe)
   );

   function automatic logic [15:0] erased_word();
      return 16'hFFFF;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic b);
      sdi = b;
      wait_clk(H);
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
   endtask

   task automatic select();
      cs = 1'b1;
      wait_clk(H);
   endtask

   task automatic deselect();
      sdi = 1'b0;
      cs  = 1'b0;
      wait_clk(2 * H);
   endtask

   task automatic send_hdr(input logic [1:0] op, input logic [5:0] a, input int lead);
      select();
      repeat (lead) sbit(1'b0);
      sbit(1'b1);
      sbit(op[1]);
      sbit(op[0]);
      for (int i = 5; i >= 0; i--) sbit(a[i]);
   endtask

   task automatic send_data(input logic [15:0] d);
      for (int i = 15; i >= 0; i--) sbit(d[i]);
   endtask

   task automatic do_read(input logic [5:0] a, input int lead, input string req);
      logic [15:0] w;
      send_hdr(2'b10, a, lead);
      check({req, " placeholder"}, {30'd0, sdo_oe, sdo}, 32'd2);
      for (int i = 15; i >= 0; i--) begin
         sbit(1'b0);
         w[i] = sdo;
      end
      check({req, " word"}, {16'd0, w}, {16'd0, mem_m[a]});
      sbit(1'b0);
      check("R3 oe after last bit", {31'd0, sdo_oe}, 32'd0);
      deselect();
   endtask

   task automatic do_write(input logic [5:0] a, input logic [15:0] d);
      send_hdr(2'b01, a, 0);
      send_data(d);
      check("R11 oe low after write", {31'd0, sdo_oe}, 32'd0);
      deselect();
      if (en_m) begin
         mem_m[a] = d;
         wait_clk(PROG + 40);
      end
   endtask

   task automatic do_erase(input logic [5:0] a);
      send_hdr(2'b11, a, 0);
      deselect();
      if (en_m) begin
         mem_m[a] = erased_word();
         wait_clk(PROG + 40);
      end
   endtask

   task automatic do_special(input logic [1:0] sub, input logic [15:0] d);
      send_hdr(2'b00, {sub, 4'b1010}, 0);
      if (sub == 2'b01) send_data(d);
      check("R11 oe low after special", {31'd0, sdo_oe}, 32'd0);
      deselect();
      case (sub)
         2'b11: en_m = 1'b1;
         2'b00: en_m = 1'b0;
         default: begin
            if (en_m) begin
               for (int w = 0; w < 64; w++) mem_m[w] = (sub == 2'b10) ? erased_word() : d;
               wait_clk(PROG + 40);
            end
         end
      endcase
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin : main
      logic [5:0]  a;
      logic [15:0] d;
      void'($urandom(32'd12345));
      for (int w = 0; w < 64; w++) mem_m[w] = 16'h0000;
      en_m = 1'b0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);

      // R1: reset state, write ignored before enable
      check("R1 oe at reset", {31'd0, sdo_oe}, 32'd0);
      do_write(6'd5, 16'h1234);
      do_read(6'd5, 0, "R1 R12 write before enable");

      // R6: enable, then several writes stay enabled; R2 with leading zeros
      do_special(2'b11, 16'h0);
      do_write(6'd5, 16'hA55A);
      do_write(6'd63, 16'h8001);
      do_write(6'd0, 16'h7FFE);
      do_read(6'd5, 2, "R2 R4 leading zeros");
      do_read(6'd63, 0, "R4 R6 top address");
      do_read(6'd0, 1, "R4 R6 address zero");

      // R5: single erase
      do_erase(6'd63);
      do_read(6'd63, 0, "R5 erase word");
      do_read(6'd0, 0, "R5 neighbour untouched");

      // R8: status busy then ready, cs held through start
      send_hdr(2'b01, 6'd9, 0);
      send_data(16'hBEEF);
      mem_m[9] = 16'hBEEF;
      deselect();
      select();
      check("R8 status busy", {30'd0, sdo_oe, sdo}, 32'd2);
      wait_clk(PROG + 40);
      check("R8 status ready", {30'd0, sdo_oe, sdo}, 32'd3);
      deselect();
      check("R11 oe low deselected", {31'd0, sdo_oe}, 32'd0);

      // R9: cs raised only after cycle ended
      send_hdr(2'b11, 6'd20, 0);
      mem_m[20] = erased_word();
      deselect();
      wait_clk(PROG + 40);
      select();
      check("R9 no late status", {31'd0, sdo_oe}, 32'd0);
      deselect();

      // R10: command during busy ignored
      send_hdr(2'b01, 6'd30, 0);
      send_data(16'h1111);
      mem_m[30] = 16'h1111;
      deselect();
      send_hdr(2'b01, 6'd31, 0);
      send_data(16'h2222);
      deselect();
      wait_clk(PROG + 40);
      do_read(6'd31, 0, "R10 busy command ignored");
      do_read(6'd30, 0, "R10 first write kept");

      // R7: write all and erase all
      do_special(2'b01, 16'h3C3C);
      do_read(6'd0, 0, "R7 write all low");
      do_read(6'd47, 0, "R7 write all mid");
      do_special(2'b10, 16'h0);
      do_read(6'd12, 0, "R7 erase all");

      // R12 and R3: disable, programming ignored, read still works
      do_write(6'd3, 16'h0F0F);
      do_special(2'b00, 16'h0);
      do_write(6'd3, 16'h5555);
      do_erase(6'd4);
      do_special(2'b01, 16'h9999);
      do_special(2'b10, 16'h0);
      do_read(6'd3, 0, "R3 R12 read while disabled");
      do_read(6'd4, 0, "R12 erase ignored");

      // Random mix checked against the model
      for (int n = 0; n < 40; n++) begin
         a = 6'($urandom % 64);
         d = 16'($urandom);
         case ($urandom % 6)
            0, 1: do_read(a, int'($urandom % 3), "R3 random read");
            2: do_write(a, d);
            3: do_erase(a);
            4: do_special(2'b11, 16'h0);
            default: begin
               if ($urandom % 3 == 0) do_special(2'b00, 16'h0);
               else do_special(2'b11, 16'h0);
            end
         endcase
      end
      for (int w = 0; w < 64; w += 9) do_read(6'(w), 0, "R4 R5 final sweep");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule